// File: doc/BRIEF.md
# Dual Gated Timer/Counter Unit

This block holds two independent timer/counters. Each one keeps a low and a high count byte, and one shared 8-bit mode register controls both. A channel advances on one of two internal tick inputs, chosen per channel, or on falling edges of its own external count pin. A run-enable input starts and stops the channel. If its gate option is set, the channel counts only while its external gate pin is high. Each channel has four modes: a 13-bit count, a 16-bit count, an 8-bit count that reloads from the high byte, and a fourth mode that differs between the channels. In that fourth mode channel 1 stops. Channel 0 splits into two 8-bit counters, and its high half takes over the overflow flag of channel 1.

Software sets up the unit through a small register port. It watches the two sticky overflow flags and clears them with dedicated clear inputs. The tick inputs come from a prescaler outside this block. The flags feed an interrupt controller, which is also outside this block.

Top module: `dual_timer_unit`

## Requirements
- R1: After reset the mode register, all four count bytes and both overflow flags are zero.
- R2: Register port addresses are 0 for the mode register, 1 and 2 for the channel 0 low and high bytes, and 3 and 4 for the channel 1 low and high bytes. A write takes effect on the next clock edge. Read data is combinational from the address. Mode bits [3:0] control channel 0 and bits [7:4] control channel 1. Within each nibble, bit 3 is the gate option, bit 2 picks external counting, and bits 1:0 hold the mode.
- R3: A channel advances only while its run-enable is 1. If its gate option is 1, it also needs its gate pin to be 1. If its gate option is 0, the gate pin has no effect.
- R4: When external counting is off, a channel advances once per cycle in which its selected tick is 1. Tick-select 0 picks tick_a and tick-select 1 picks tick_b; the unselected tick is ignored.
- R5: When external counting is on, a channel advances exactly once for each high-to-low transition of its count pin, after a short synchronizing delay. A pin held at one level adds nothing.
- R6: Mode 00 counts 13 bits: low bits [4:0] below the whole high byte. Low bits [7:5] are never changed by counting. Wrapping from 0x1FFF to 0 sets the channel's overflow flag.
- R7: Mode 01 counts 16 bits, high byte over low byte. Wrapping from 0xFFFF to 0 sets the overflow flag.
- R8: In mode 10 only the low byte counts. An increment from 0xFF loads the low byte with the high byte and sets the overflow flag; the high byte never changes by counting.
- R9: Mode 11 on channel 1 holds both of its count bytes.
- R10: Mode 11 on channel 0 splits it. The low byte counts as an 8-bit counter under channel 0's controls and sets flag 0 on wrap. The high byte counts channel 0's selected internal tick while channel 1's run-enable is 1, and its wrap sets flag 1. During the split, channel 1's own wraps do not set flag 1.
- R11: An overflow flag stays set until its clear input is 1. An overflow in the same cycle as a clear leaves the flag set.
- R12: A register write to either count byte of a channel cancels that channel's increment and overflow in that cycle. In split mode this applies to the written half only. The written byte takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | BYTE_W | Register write data |
| reg_rdata | output | BYTE_W | Register read data |
| run_en | input | 2 | Run-enable per channel |
| cnt_pin | input | 2 | External count pin per channel |
| gate_pin | input | 2 | External gate level per channel |
| tick_sel | input | 2 | Internal tick select per channel (0: tick_a, 1: tick_b) |
| tick_a | input | 1 | First internal tick |
| tick_b | input | 1 | Second internal tick |
| ovf_clr | input | 2 | Overflow flag clear per channel |
| ovf_flag | output | 2 | Sticky overflow flag per channel |

## Verification
An internal fault shows up at the ports as a wrong count byte on the next read after the step that went wrong, or as a wrong flag on the cycle after that step. A bad carry in the 13-bit path shows up only when the low five bits wrap. A bad reload shows up only at 0xFF. A missed stop or gate shows up as a count that moves while it should be frozen. For these reasons the stimulus biases its start values toward the top of each range, so that wraps and flag updates occur in nearly every run. It also keeps the unselected tick, the gate pin and the idle count pin toggling, so that any leakage from them changes a count.

// File: rtl/dtu_pkg.sv
`timescale 1ns/1ps
package dtu_pkg;

   typedef enum logic [1:0] {
      MODE_PRE13   = 2'b00,
      MODE_FULL16  = 2'b01,
      MODE_RELOAD8 = 2'b10,
      MODE_SPLIT   = 2'b11
   } dtu_mode_e;

   typedef struct packed {
      logic      gate_on;
      logic      ext_sel;
      dtu_mode_e mode;
   } dtu_nib_t;

   localparam int unsigned NIB_W    = 4;
   localparam int unsigned N_CHAN   = 2;
   localparam int unsigned ADR_MODE = 0;
   localparam int unsigned ADR_C0LO = 1;
   localparam int unsigned ADR_C0HI = 2;
   localparam int unsigned ADR_C1LO = 3;
   localparam int unsigned ADR_C1HI = 4;

endpackage

// File: rtl/dtu_ctl.sv
`timescale 1ns/1ps
module dtu_ctl #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cnt_pin,
   input  logic gate_pin,
   input  logic run_en,
   input  logic gate_on,
   input  logic ext_sel,
   input  logic tick_sel,
   input  logic tick_a,
   input  logic tick_b,
   output logic step,
   output logic int_tick
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;
   logic                   fall;
   logic                   enabled;

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("dtu_ctl: SYNC_STAGES must be at least 1");
      end
      if (SYNC_STAGES == 1) begin : g_sync_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= cnt_pin;
         end
      end else begin : g_sync_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], cnt_pin};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sync_q[SYNC_STAGES-1];
   end

   assign fall     = last_q & ~sync_q[SYNC_STAGES-1];
   assign enabled  = run_en & (~gate_on | gate_pin);
   assign int_tick = tick_sel ? tick_b : tick_a;
   assign step     = enabled & (ext_sel ? fall : int_tick);

endmodule

// File: rtl/dtu_chan.sv
`timescale 1ns/1ps
module dtu_chan
   import dtu_pkg::*;
#(
   parameter int BYTE_W   = 8,
   parameter int PRE_W    = 5,
   parameter bit SPLIT_OK = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  dtu_mode_e         mode,
   input  logic              step,
   input  logic              aux_step,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] lo_q,
   output logic [BYTE_W-1:0] hi_q,
   output logic [1:0]        ovf
);

   localparam int              WIDE_W  = 2 * BYTE_W;
   localparam logic [BYTE_W-1:0] B_ONE  = BYTE_W'(1);
   localparam logic [BYTE_W-1:0] B_MAX  = '1;
   localparam logic [PRE_W-1:0]  P_ONE  = PRE_W'(1);
   localparam logic [PRE_W-1:0]  P_MAX  = '1;
   localparam logic [WIDE_W-1:0] W_ONE  = WIDE_W'(1);

   logic [BYTE_W-1:0] lo_n, hi_n;
   logic [BYTE_W-1:0] sp_lo, sp_hi;
   logic              sp_ovf, sp_aux;
   logic              main_ovf, aux_ovf;
   logic              wr_any;

   assign wr_any = wr_lo | wr_hi;

   generate
      if (PRE_W < 1 || PRE_W >= BYTE_W) begin : g_bad_pre
         $error("dtu_chan: PRE_W must lie between 1 and BYTE_W-1");
      end
      if (SPLIT_OK) begin : g_split
         always_comb begin
            sp_lo  = lo_q;
            sp_hi  = hi_q;
            sp_ovf = 1'b0;
            sp_aux = 1'b0;
            if (step && !wr_lo) begin
               sp_lo  = lo_q + B_ONE;
               sp_ovf = (lo_q == B_MAX);
            end
            if (aux_step && !wr_hi) begin
               sp_hi  = hi_q + B_ONE;
               sp_aux = (hi_q == B_MAX);
            end
         end
      end else begin : g_stop
         always_comb begin
            sp_lo  = lo_q;
            sp_hi  = hi_q;
            sp_ovf = 1'b0;
            sp_aux = 1'b0;
         end
      end
   endgenerate

   always_comb begin
      lo_n     = lo_q;
      hi_n     = hi_q;
      main_ovf = 1'b0;
      aux_ovf  = 1'b0;
      unique case (mode)
         MODE_PRE13: begin
            if (step && !wr_any) begin
               if (lo_q[PRE_W-1:0] == P_MAX) begin
                  lo_n[PRE_W-1:0] = '0;
                  hi_n            = hi_q + B_ONE;
                  main_ovf        = (hi_q == B_MAX);
               end else begin
                  lo_n[PRE_W-1:0] = lo_q[PRE_W-1:0] + P_ONE;
               end
            end
         end
         MODE_FULL16: begin
            if (step && !wr_any) begin
               {hi_n, lo_n} = {hi_q, lo_q} + W_ONE;
               main_ovf     = (hi_q == B_MAX) && (lo_q == B_MAX);
            end
         end
         MODE_RELOAD8: begin
            if (step && !wr_any) begin
               if (lo_q == B_MAX) begin
                  lo_n     = hi_q;
                  main_ovf = 1'b1;
               end else begin
                  lo_n = lo_q + B_ONE;
               end
            end
         end
         MODE_SPLIT: begin
            lo_n     = sp_lo;
            hi_n     = sp_hi;
            main_ovf = sp_ovf;
            aux_ovf  = sp_aux;
         end
      endcase
      if (wr_lo) lo_n = wdata;
      if (wr_hi) hi_n = wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         lo_q <= lo_n;
         hi_q <= hi_n;
      end
   end

   assign ovf = {aux_ovf, main_ovf};

endmodule

// File: rtl/dual_timer_unit.sv
`timescale 1ns/1ps
module dual_timer_unit
   import dtu_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int PRE_W       = 5,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [BYTE_W-1:0] reg_wdata,
   output logic [BYTE_W-1:0] reg_rdata,
   input  logic [1:0]        run_en,
   input  logic [1:0]        cnt_pin,
   input  logic [1:0]        gate_pin,
   input  logic [1:0]        tick_sel,
   input  logic              tick_a,
   input  logic              tick_b,
   input  logic [1:0]        ovf_clr,
   output logic [1:0]        ovf_flag
);

   localparam int MODE_W = N_CHAN * NIB_W;

   generate
      if (BYTE_W < MODE_W) begin : g_bad_byte
         $error("dual_timer_unit: BYTE_W must hold the mode register");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("dual_timer_unit: ADDR_W must reach address 4");
      end
   endgenerate

   logic [MODE_W-1:0] mode_q;
   dtu_nib_t          nib      [N_CHAN];
   logic [N_CHAN-1:0] step, int_tick, aux_step, wr_lo, wr_hi, flag_set;
   logic [BYTE_W-1:0] cnt_lo   [N_CHAN];
   logic [BYTE_W-1:0] cnt_hi   [N_CHAN];
   logic [1:0]        chan_ovf [N_CHAN];
   logic [BYTE_W-1:0] c0_lo, c0_hi, c1_lo, c1_hi;
   logic              split0;
   logic              wr_mode;

   assign wr_mode  = reg_we && (reg_addr == ADDR_W'(ADR_MODE));
   assign wr_lo[0] = reg_we && (reg_addr == ADDR_W'(ADR_C0LO));
   assign wr_hi[0] = reg_we && (reg_addr == ADDR_W'(ADR_C0HI));
   assign wr_lo[1] = reg_we && (reg_addr == ADDR_W'(ADR_C1LO));
   assign wr_hi[1] = reg_we && (reg_addr == ADDR_W'(ADR_C1HI));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= '0;
      else if (wr_mode) mode_q <= reg_wdata[MODE_W-1:0];
   end

   assign split0 = (nib[0].mode == MODE_SPLIT);

   genvar gi;
   generate
      for (gi = 0; gi < N_CHAN; gi++) begin : g_chan
         assign nib[gi] = dtu_nib_t'(mode_q[gi*NIB_W +: NIB_W]);

         dtu_ctl #(
            .SYNC_STAGES(SYNC_STAGES)
         ) u_ctl (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt_pin  (cnt_pin[gi]),
            .gate_pin (gate_pin[gi]),
            .run_en   (run_en[gi]),
            .gate_on  (nib[gi].gate_on),
            .ext_sel  (nib[gi].ext_sel),
            .tick_sel (tick_sel[gi]),
            .tick_a   (tick_a),
            .tick_b   (tick_b),
            .step     (step[gi]),
            .int_tick (int_tick[gi])
         );

         if (gi == 0) begin : g_aux_split
            assign aux_step[gi] = split0 & run_en[1] & int_tick[0];
         end else begin : g_aux_none
            assign aux_step[gi] = 1'b0;
         end

         dtu_chan #(
            .BYTE_W   (BYTE_W),
            .PRE_W    (PRE_W),
            .SPLIT_OK (gi == 0)
         ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode     (nib[gi].mode),
            .step     (step[gi]),
            .aux_step (aux_step[gi]),
            .wr_lo    (wr_lo[gi]),
            .wr_hi    (wr_hi[gi]),
            .wdata    (reg_wdata),
            .lo_q     (cnt_lo[gi]),
            .hi_q     (cnt_hi[gi]),
            .ovf      (chan_ovf[gi])
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             ovf_flag[gi] <= 1'b0;
            else if (flag_set[gi])  ovf_flag[gi] <= 1'b1;
            else if (ovf_clr[gi])   ovf_flag[gi] <= 1'b0;
         end
      end
   endgenerate

   assign flag_set[0] = chan_ovf[0][0];
   assign flag_set[1] = split0 ? chan_ovf[0][1] : (chan_ovf[1][0] | chan_ovf[1][1]);

   assign c0_lo = cnt_lo[0];
   assign c0_hi = cnt_hi[0];
   assign c1_lo = cnt_lo[1];
   assign c1_hi = cnt_hi[1];

   always_comb begin
      unique case (reg_addr)
         ADDR_W'(ADR_MODE): reg_rdata = BYTE_W'(mode_q);
         ADDR_W'(ADR_C0LO): reg_rdata = c0_lo;
         ADDR_W'(ADR_C0HI): reg_rdata = c0_hi;
         ADDR_W'(ADR_C1LO): reg_rdata = c1_lo;
         ADDR_W'(ADR_C1HI): reg_rdata = c1_hi;
         default:           reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/dtu_checker.sv
`timescale 1ns/1ps
module dtu_checker #(
   parameter int BYTE_W = 8,
   parameter int PRE_W  = 5,
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [BYTE_W-1:0] reg_wdata,
   input logic [1:0]        run_en,
   input logic [1:0]        gate_pin,
   input logic [1:0]        ovf_clr,
   input logic [1:0]        ovf_flag,
   input logic [7:0]        mode_q,
   input logic [BYTE_W-1:0] c0_lo,
   input logic [BYTE_W-1:0] c0_hi,
   input logic [BYTE_W-1:0] c1_lo,
   input logic [BYTE_W-1:0] c1_hi
);

   logic wr_c0lo, wr_c0hi, wr_c0, wr_c1, split0;

   assign wr_c0lo = reg_we && (reg_addr == ADDR_W'(1));
   assign wr_c0hi = reg_we && (reg_addr == ADDR_W'(2));
   assign wr_c0   = wr_c0lo || wr_c0hi;
   assign wr_c1   = reg_we && (reg_addr == ADDR_W'(3) || reg_addr == ADDR_W'(4));
   assign split0  = (mode_q[1:0] == 2'b11);

   assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (mode_q == 8'h00 && ovf_flag == 2'b00));

   assert_gate_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!split0 && (!run_en[0] || (mode_q[3] && !gate_pin[0])) && !wr_c0)
      |=> ($stable(c0_lo) && $stable(c0_hi)));

   assert_pre_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[1:0] == 2'b00 && !wr_c0) |=> $stable(c0_lo[BYTE_W-1:PRE_W]));

   assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[1:0] == 2'b10 && c0_lo == '1 && !wr_c0)
      |=> ((c0_lo == $past(c0_hi) || c0_lo == '1) && $stable(c0_hi)));

   assert_ch1_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[5:4] == 2'b11 && !wr_c1) |=> ($stable(c1_lo) && $stable(c1_hi)));

   assert_split_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (split0 && !run_en[1] && !wr_c0hi) |=> $stable(c0_hi));

   assert_flag0_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag[0] && !ovf_clr[0]) |=> ovf_flag[0]);

   assert_flag1_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag[1] && !ovf_clr[1]) |=> ovf_flag[1]);

   assert_write_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
      wr_c0lo |=> (c0_lo == $past(reg_wdata)));

endmodule

bind dual_timer_unit dtu_checker #(
   .BYTE_W (BYTE_W),
   .PRE_W  (PRE_W),
   .ADDR_W (ADDR_W)
) u_dtu_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .run_en    (run_en),
   .gate_pin  (gate_pin),
   .ovf_clr   (ovf_clr),
   .ovf_flag  (ovf_flag),
   .mode_q    (mode_q),
   .c0_lo     (c0_lo),
   .c0_hi     (c0_hi),
   .c1_lo     (c1_lo),
   .c1_hi     (c1_hi)
);

// File: tb/dual_timer_unit_bench.sv
`timescale 1ns/1ps
module dual_timer_unit_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [1:0] run_en = '0;
   logic [1:0] cnt_pin = 2'b11;
   logic [1:0] gate_pin = '0;
   logic [1:0] tick_sel = '0;
   logic       tick_a = 1'b0;
   logic       tick_b = 1'b0;
   logic [1:0] ovf_clr = '0;
   logic [1:0] ovf_flag;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dual_timer_unit u_dual_timer_unit (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .run_en(run_en),
      .cnt_pin(cnt_pin), .gate_pin(gate_pin), .tick_sel(tick_sel),
      .tick_a(tick_a), .tick_b(tick_b), .ovf_clr(ovf_clr), .ovf_flag(ovf_flag)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic rd_check(input string req, input logic [2:0] a, input logic [7:0] exp);
      logic [7:0] d;
      rd(a, d);
      check(req, {24'h0, d}, {24'h0, exp});
   endtask

   task automatic clear_flags();
      @(negedge clk);
      ovf_clr = 2'b11;
      @(negedge clk);
      ovf_clr = 2'b00;
   endtask

   task automatic pulse_a(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_a = 1'b1;
         @(negedge clk); tick_a = 1'b0;
      end
   endtask

   // Reference step of one count per the mode rules (R6, R7, R8, R9)
   function automatic void model_step(input logic [1:0] m, inout logic [7:0] lo,
                                      inout logic [7:0] hi, inout bit ov);
      case (m)
         2'b00: if (lo[4:0] == 5'h1f) begin
                   lo[4:0] = 5'h00;
                   if (hi == 8'hff) ov = 1'b1;
                   hi = hi + 8'd1;
                end else lo[4:0] = lo[4:0] + 5'd1;
         2'b01: begin
                   if ({hi, lo} == 16'hffff) ov = 1'b1;
                   {hi, lo} = {hi, lo} + 16'd1;
                end
         2'b10: if (lo == 8'hff) begin lo = hi; ov = 1'b1; end
                else lo = lo + 8'd1;
         default: ;
      endcase
   endfunction

   function automatic string mode_req(input logic [1:0] m);
      case (m)
         2'b00: return "R4 R6";
         2'b01: return "R4 R7";
         default: return "R4 R8";
      endcase
   endfunction

   function automatic logic [7:0] biased();
      return ($urandom % 3 == 0) ? (8'hff - 8'($urandom % 3)) : 8'($urandom);
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired before the run completed");
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] lo [2];
      logic [7:0] hi [2];
      logic [1:0] md [2];
      bit         ov [2];
      void'($urandom(32'd20240611));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a < 5; a++) rd_check("R1 reset byte", 3'(a), 8'h00);
      check("R1 reset flags", {30'h0, ovf_flag}, 32'h0);

      // R2 readback
      wr(3'd0, 8'ha5); wr(3'd1, 8'h3c); wr(3'd2, 8'hc3); wr(3'd3, 8'h5a); wr(3'd4, 8'h96);
      rd_check("R2 mode", 3'd0, 8'ha5);
      rd_check("R2 c0lo", 3'd1, 8'h3c);
      rd_check("R2 c0hi", 3'd2, 8'hc3);
      rd_check("R2 c1lo", 3'd3, 8'h5a);
      rd_check("R2 c1hi", 3'd4, 8'h96);
      rd_check("R2 unmapped", 3'd6, 8'h00);
      wr(3'd0, 8'h00);

      // Random timer runs, both channels, modes 00/01/10
      run_en = 2'b11;
      for (int it = 0; it < 40; it++) begin
         for (int c = 0; c < 2; c++) begin
            md[c] = 2'($urandom % 3);
            lo[c] = biased();
            hi[c] = biased();
            ov[c] = 1'b0;
         end
         tick_sel = 2'($urandom);
         wr(3'd0, {2'b00, md[1], 2'b00, md[0]});
         wr(3'd1, lo[0]); wr(3'd2, hi[0]); wr(3'd3, lo[1]); wr(3'd4, hi[1]);
         clear_flags();
         for (int cyc = 0; cyc < int'($urandom % 70); cyc++) begin
            @(negedge clk);
            tick_a = 1'($urandom); tick_b = 1'($urandom);
            gate_pin = 2'($urandom); cnt_pin = 2'($urandom);
            for (int c = 0; c < 2; c++)
               if (tick_sel[c] ? tick_b : tick_a) model_step(md[c], lo[c], hi[c], ov[c]);
         end
         @(negedge clk);
         tick_a = 1'b0; tick_b = 1'b0; cnt_pin = 2'b11;
         rd_check({mode_req(md[0]), " c0lo"}, 3'd1, lo[0]);
         rd_check({mode_req(md[0]), " c0hi"}, 3'd2, hi[0]);
         rd_check({mode_req(md[1]), " c1lo"}, 3'd3, lo[1]);
         rd_check({mode_req(md[1]), " c1hi"}, 3'd4, hi[1]);
         check({mode_req(md[0]), " flag0"}, {31'h0, ovf_flag[0]}, {31'h0, ov[0]});
         check({mode_req(md[1]), " flag1"}, {31'h0, ovf_flag[1]}, {31'h0, ov[1]});
      end
      tick_sel = 2'b00; gate_pin = 2'b00;

      // R3 gate and run-enable
      wr(3'd0, 8'h09); wr(3'd1, 8'h10); wr(3'd2, 8'h00);
      pulse_a(5);
      rd_check("R3 gate low blocks", 3'd1, 8'h10);
      gate_pin[0] = 1'b1;
      pulse_a(5);
      rd_check("R3 gate high counts", 3'd1, 8'h15);
      wr(3'd0, 8'h01); run_en[0] = 1'b0;
      pulse_a(5);
      rd_check("R3 run off blocks", 3'd1, 8'h15);
      run_en[0] = 1'b1;

      // R4 unselected tick ignored
      tick_sel[0] = 1'b1;
      pulse_a(4);
      rd_check("R4 unselected tick", 3'd1, 8'h15);
      tick_sel[0] = 1'b0;

      // R5 external falling edges on channel 1
      wr(3'd0, 8'h51); wr(3'd3, 8'h00); wr(3'd4, 8'h00);
      for (int p = 0; p < 7; p++) begin
         @(negedge clk); cnt_pin[1] = 1'b0; tick_a = 1'b1;
         repeat (5) @(negedge clk);
         tick_a = 1'b0; cnt_pin[1] = 1'b1;
         repeat (5) @(negedge clk);
      end
      rd_check("R5 edge count", 3'd3, 8'h07);
      cnt_pin[1] = 1'b0;
      repeat (10) @(negedge clk);
      cnt_pin[1] = 1'b1;
      repeat (2) @(negedge clk);
      rd_check("R5 one edge for long low", 3'd3, 8'h08);
      repeat (8) @(negedge clk);
      rd_check("R5 rise adds nothing", 3'd3, 8'h08);

      // R9 channel 1 stopped
      wr(3'd0, 8'h31); wr(3'd3, 8'h34); wr(3'd4, 8'h12);
      pulse_a(10);
      rd_check("R9 c1lo held", 3'd3, 8'h34);
      rd_check("R9 c1hi held", 3'd4, 8'h12);

      // R10 split channel 0
      wr(3'd0, 8'h13); wr(3'd1, 8'hfe); wr(3'd2, 8'h10); wr(3'd3, 8'hff); wr(3'd4, 8'hff);
      clear_flags();
      run_en = 2'b01;
      pulse_a(3);
      rd_check("R10 low half", 3'd1, 8'h01);
      rd_check("R10 high half idle", 3'd2, 8'h10);
      check("R10 flag0", {30'h0, ovf_flag}, 32'h1);
      clear_flags();
      run_en = 2'b10;
      pulse_a(3);
      rd_check("R10 low half idle", 3'd1, 8'h01);
      rd_check("R10 high half", 3'd2, 8'h13);
      rd_check("R10 ch1 still counts", 3'd3, 8'h02);
      check("R10 ch1 wrap hidden", {30'h0, ovf_flag}, 32'h0);
      wr(3'd2, 8'hff);
      pulse_a(1);
      rd_check("R10 high wrap", 3'd2, 8'h00);
      check("R10 flag1", {30'h0, ovf_flag}, 32'h2);
      run_en = 2'b11;

      // R11 set beats clear
      wr(3'd0, 8'h02); wr(3'd1, 8'hff); wr(3'd2, 8'h40);
      clear_flags();
      @(negedge clk); tick_a = 1'b1; ovf_clr = 2'b01;
      @(negedge clk); tick_a = 1'b0; ovf_clr = 2'b00;
      check("R11 set wins", {31'h0, ovf_flag[0]}, 32'h1);
      rd_check("R11 reload", 3'd1, 8'h40);
      repeat (3) @(negedge clk);
      check("R11 sticky", {31'h0, ovf_flag[0]}, 32'h1);
      clear_flags();
      check("R11 cleared", {31'h0, ovf_flag[0]}, 32'h0);

      // R12 write priority
      wr(3'd0, 8'h01); wr(3'd1, 8'h10); wr(3'd2, 8'h00);
      @(negedge clk); tick_a = 1'b1; reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h77;
      @(negedge clk); reg_addr = 3'd2; reg_wdata = 8'h05;
      @(negedge clk); tick_a = 1'b0; reg_we = 1'b0;
      rd_check("R12 written low", 3'd1, 8'h77);
      rd_check("R12 written high", 3'd2, 8'h05);
      wr(3'd1, 8'hff); wr(3'd2, 8'hff);
      clear_flags();
      @(negedge clk); tick_a = 1'b1; reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 8'h20;
      @(negedge clk); tick_a = 1'b0; reg_we = 1'b0;
      rd_check("R12 low not advanced", 3'd1, 8'hff);
      check("R12 no overflow", {31'h0, ovf_flag[0]}, 32'h0);

      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule